// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Pair

This block holds the pending-interrupt flags of a small peripheral and the mask that enables them. A plain register port with a one-bit address reaches it. Address 0 is the flag register and address 1 is the mask register. Each bit has its own event input. A single-cycle pulse on that input latches the flag. The block raises its interrupt request while any effective flag is set and its mask bit is enabled.

Each bit position is given one of three behaviours by a parameter vector, with two bits per flag:
- **Software-cleared flag (code 0).** A write of one to the flag's position clears it, and a write of zero leaves it alone. Several flags can be acknowledged in one write without disturbing the others. A read of the register followed by a write of that same value clears every flag that was set at the read. The block does not guard against this.
- **Hardware-cleared flag (code 1).** The flag is read-only to software and clears only through its hardware clear input or reset.
- **Level source (code 2).** There is no latch. The read-back value and the request contribution follow the live input directly.

By convention a timer overflow source sits at bit 0 and a compare-match source at bit 1.

The register port is a control port, not a data stream. It has no handshake and no back-pressure. A write takes effect at the rising edge on which `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `irqf_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every latched flag and every mask bit is 0, so with all level inputs low the flag read, the mask read and `irq` are all 0.
- R2: In a software-cleared bit (mode code 0), a write to address 0 with a 1 at that position clears the flag at the next rising edge. A 0 at that position leaves the flag unchanged. For example, flags 0x07 written with 0x02 read back 0x05.
- R3: Writing to address 0 the value just read from address 0 clears every software-cleared flag that was set at the read.
- R4: A one-cycle pulse on `evt_set[i]` sets latched flag i at that rising edge. When that pulse coincides with a software clear (R2) or a hardware clear (R5) of the same bit, the set wins.
- R5: A hardware-cleared bit (mode code 1) ignores all writes. It clears only when `hw_clr[i]` is high at a rising edge (with no set) or on reset.
- R6: A level bit (mode code 2) reads back `lvl_in[i]` combinationally, with no clock edge needed, and writes to it have no effect.
- R7: A write to address 1 loads `wr_data` into the mask at the next rising edge. A read of address 1 returns the mask and a read of address 0 returns the effective flags.
- R8: `irq` is high exactly when some bit has both its effective flag and its mask bit at 1.
- R9: Bit modes come from the `FLAG_MODES` parameter, two bits per flag with bit i at [2i+1:2i]. The default for 8 bits is 0xA500: bits 0 to 3 software-cleared, bits 4 and 5 hardware-cleared, bits 6 and 7 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 flags, 1 mask |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 1 | Read address: 0 flags, 1 mask |
| rd_data | output | WIDTH | Combinational read data |
| evt_set | input | WIDTH | Per-bit single-cycle set pulses |
| hw_clr | input | WIDTH | Per-bit hardware clear, used by hardware-cleared bits |
| lvl_in | input | WIDTH | Per-bit live level, used by level bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes 0x02 over flags 0x07. A design that ran a read-modify-write internally, or treated written zeros as clears, would return something other than 0x05.

It reads the flags and writes the same value back. A design that protected flags from that write-back would leave bits standing.

It fires a set pulse and a clear on the same bit in one cycle. A design that let the clear win would drop the event.

It writes all ones over hardware-cleared bits and over level bits. It also moves a level input between clock edges. A design that wired those bits through the latch would lose the flag or lag the input by a cycle.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    MODE_SWCLR = 2'd0,
    MODE_HWCLR = 2'd1,
    MODE_LEVEL = 2'd2
  } flag_mode_e;
endpackage

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell #(
  parameter logic [1:0] CELL_MODE = 2'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  input  logic level_in,
  output logic eff_flag
);
  if (CELL_MODE == irqf_pkg::MODE_LEVEL) begin : g_level
    logic unused_level;
    assign unused_level = ^{clk, rst_n, set_pulse, clr_req};
    assign eff_flag = level_in;
  end else begin : g_latched
    logic flag_q;
    logic unused_latched;
    assign unused_latched = level_in;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_pulse) flag_q <= 1'b1;
      else if (clr_req)   flag_q <= 1'b0;
    end
    assign eff_flag = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> flag_q); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_pulse) |=> !flag_q); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req && !set_pulse) |=> $stable(flag_q)); // R2
  end
endmodule

// File: rtl/irqf_mask_reg.sv
module irqf_mask_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= din;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == $past(din))); // R7
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask_q)); // R7
endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl #(
  parameter int                   WIDTH      = 8,
  parameter logic [2*WIDTH-1:0]   FLAG_MODES = 16'hA500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] evt_set,
  input  logic [WIDTH-1:0] hw_clr,
  input  logic [WIDTH-1:0] lvl_in,
  output logic             irq
);
  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;

  logic [WIDTH-1:0] eff_flags;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] clr_sel;
  logic             flag_wr;

  assign flag_wr = wr_en && (wr_addr == ADDR_FLAGS);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic [1:0] BMODE = FLAG_MODES[2*i +: 2];

    if (BMODE == irqf_pkg::MODE_SWCLR) begin : g_sw
      assign clr_sel[i] = flag_wr && wr_data[i];
    end else if (BMODE == irqf_pkg::MODE_HWCLR) begin : g_hw
      assign clr_sel[i] = hw_clr[i];
      AST_RO_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !evt_set[i] && !hw_clr[i]) |=> $stable(eff_flags[i])); // R5
    end else begin : g_lv
      assign clr_sel[i] = 1'b0;
    end

    irqf_flag_cell #(.CELL_MODE(BMODE)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(evt_set[i]),
      .clr_req  (clr_sel[i]),
      .level_in (lvl_in[i]),
      .eff_flag (eff_flags[i])
    );
  end

  irqf_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_en && (wr_addr == ADDR_MASK)),
    .din   (wr_data),
    .mask_q(mask_q)
  );

  assign rd_data = (rd_addr == ADDR_MASK) ? mask_q : eff_flags;
  assign irq     = |(eff_flags & mask_q);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eff_flags != '0)); // R8
endmodule

// File: tb/tb_irqf_ctrl.sv
module tb_irqf_ctrl;
  localparam int             W        = 8;
  localparam logic [2*W-1:0] MODES    = 16'hA500;
  localparam int             CLK_PER  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [W-1:0] wr_data = '0, evt_set = '0, hw_clr = '0, lvl_in = '0;
  logic [W-1:0] rd_data;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] m_flags = '0, m_mask = '0;

  always #(CLK_PER/2) clk = ~clk;

  irqf_ctrl #(.WIDTH(W), .FLAG_MODES(MODES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_set(evt_set), .hw_clr(hw_clr), .lvl_in(lvl_in), .irq(irq));

  function automatic logic [W-1:0] next_flags(input logic [W-1:0] cur,
      input logic we, input logic a, input logic [W-1:0] d,
      input logic [W-1:0] ev, input logic [W-1:0] hc);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      case (MODES[2*i +: 2])
        2'd0:    n[i] = ev[i] | (cur[i] & ~(we & ~a & d[i]));
        2'd1:    n[i] = ev[i] | (cur[i] & ~hc[i]);
        default: n[i] = 1'b0;
      endcase
    end
    return n;
  endfunction

  function automatic logic [W-1:0] eff(input logic [W-1:0] f, input logic [W-1:0] lv);
    logic [W-1:0] e;
    for (int i = 0; i < W; i++) e[i] = (MODES[2*i +: 2] == 2'd2) ? lv[i] : f[i];
    return e;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic a, output logic [W-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // Called at a falling edge; applies one cycle of stimulus and returns at the next falling edge.
  task automatic tick(input logic we, input logic a, input logic [W-1:0] d,
                      input logic [W-1:0] ev, input logic [W-1:0] hc);
    logic [W-1:0] nf;
    wr_en = we; wr_addr = a; wr_data = d; evt_set = ev; hw_clr = hc;
    nf = next_flags(m_flags, we, a, d, ev, hc);
    @(posedge clk);
    #1;
    m_flags = nf;
    if (we && a) m_mask = d;
    wr_en = 0; evt_set = '0; hw_clr = '0; wr_data = '0;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] v;
    peek(1'b0, v); check({tag, " flags"}, v, eff(m_flags, lvl_in));
    peek(1'b1, v); check({tag, " mask"}, v, m_mask);
    check({tag, " irq R8"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(eff(m_flags, lvl_in) & m_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    #(CLK_PER*2 + 2);
    // R1 reset state
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R4 set pulses on bits 0..2, then R2 selective clear 0x07 -> 0x05
    tick(0, 0, '0, 8'h07, '0);
    peek(0, v); check("R4 pulses latch", v, 8'h07);
    tick(1, 0, 8'h02, '0, '0);
    peek(0, v); check("R2 write 0x02 over 0x07", v, 8'h05);
    tick(1, 0, 8'h00, '0, '0);
    peek(0, v); check("R2 zeros ignored", v, 8'h05);

    // R3 read-modify-write clears all set flags
    tick(0, 0, '0, 8'h0A, '0);
    peek(0, v); check("R3 pre-read", v, 8'h0F);
    tick(1, 0, v, '0, '0);
    peek(0, v); check("R3 write-back clears all", v, 8'h00);

    // R4 set wins over software clear in the same cycle
    tick(1, 0, 8'h01, 8'h01, '0);
    peek(0, v); check("R4 set beats write-one", v, 8'h01);

    // R5 hardware-cleared bit ignores writes, clears by hw_clr, set beats hw_clr
    tick(0, 0, '0, 8'h10, '0);
    tick(1, 0, 8'hFF, '0, '0);
    peek(0, v); check("R5 write ignored on bit4", v & 8'h30, 8'h10);
    check("R2 all-ones write clears bit0", v & 8'h0F, 8'h00);
    tick(0, 0, '0, 8'h10, 8'h10);
    peek(0, v); check("R4 set beats hw clear", v & 8'h30, 8'h10);
    tick(0, 0, '0, '0, 8'h10);
    peek(0, v); check("R5 hw clear", v & 8'h30, 8'h00);

    // R6 level bits follow the live input without a clock edge
    lvl_in = 8'h40;
    peek(0, v); check("R6 level live high", v & 8'hC0, 8'h40);
    tick(1, 0, 8'hC0, '0, '0);
    peek(0, v); check("R6 write ignored on level", v & 8'hC0, 8'h40);
    lvl_in = 8'h00;
    peek(0, v); check("R6 level live low", v & 8'hC0, 8'h00);

    // R7 mask at address 1, R8 irq
    tick(1, 1, 8'h40, '0, '0);
    peek(1, v); check("R7 mask readback", v, 8'h40);
    check("R8 masked level low no irq", {7'd0, irq}, 8'h00);
    lvl_in = 8'h40; #1;
    check("R8 level enabled irq", {7'd0, irq}, 8'h01);
    tick(1, 1, 8'h00, '0, '0);
    check("R8 mask off irq low", {7'd0, irq}, 8'h00);
    lvl_in = 8'h00;

    // R9 default modes, random mix; R2 R4 R5 R6 R7 R8 checked against the model
    for (int n = 0; n < 400; n++) begin
      logic we, a;
      logic [W-1:0] d, ev, hc;
      we = ($urandom % 3) == 0;
      a  = $urandom % 2;
      d  = $urandom;
      ev = $urandom & $urandom;
      hc = $urandom & $urandom;
      lvl_in = $urandom;
      tick(we, a, d, ev, hc);
      check_all("R9 random R2 R4 R5 R6 R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule